// File: doc/BRIEF.md
# Oscillator Sub-Band Calibration Controller

This controller picks one of 32 oscillator tuning sub-bands each time a synthesizer is sent to a new output frequency. It measures the divided oscillator pulse stream against the divided reference pulse stream over fixed measurement windows. After each window it settles one bit of a 5-bit band code, most significant bit first. The code then points at the highest band whose oscillator does not run faster than the reference.

A calibration begins on a start strobe. When automatic relaunch is enabled, it can also begin on a falling edge of the lock-detect input. The whole search takes seven windows: one settling window with the code at midscale, five decision windows, and one closing window. `busy_o` stays high for the entire search. `done_o` pulses for one cycle when the final code is taken. A window is `WIN_REFS` reference pulses long. In a decision window the trial bit is cleared when the feedback pulse count is greater than `WIN_REFS`.

Top module: `vbc_top`

## Requirements
- R1: During reset and after it, the block is idle: `band_o` = 5'b10000, `busy_o` = 0, `done_o` = 0.
- R2: A `cal_start_i` strobe sampled while idle makes `busy_o` high on the next cycle, with `band_o` = 5'b10000.
- R3: `done_o` rises, and `busy_o` falls, in the cycle after the clock edge that samples the 7·`WIN_REFS`-th reference pulse following the launch edge. `done_o` is high for exactly one cycle.
- R4: In every decision window the trial bit is cleared when the window's feedback pulse count exceeds `WIN_REFS` and is kept otherwise. The next lower bit is set as the new trial bit. The final code equals the highest band that is not too fast.
- R5: `band_o` changes only at window ends. It still reads 5'b10000 after the first (settling) window. After the second window it reads {decided bit 4, 1, 000}.
- R6: A `cal_start_i` strobe while `busy_o` is high is ignored, so the running search keeps its original timing.
- R7: With `auto_relaunch_i` = 1, a high-to-low transition of `lock_i` while idle launches a calibration, exactly as R2 describes.
- R8: With `auto_relaunch_i` = 0, a falling `lock_i` is ignored: `busy_o` stays low and `band_o` is held.
- R9: A falling `lock_i` during a calibration is ignored, both during and after that calibration.
- R10: A start strobe and a lock-loss event in the same idle cycle launch exactly one calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start_i | input | 1 | One-cycle request for a calibration |
| ref_tick_i | input | 1 | One-cycle pulse per divided reference period |
| fb_tick_i | input | 1 | One-cycle pulse per divided oscillator period |
| auto_relaunch_i | input | 1 | Enables relaunch on loss of lock |
| lock_i | input | 1 | Lock-detect level |
| band_o | output | NB (5) | Selected sub-band code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the final code is taken |

## Verification
Two kinds of trigger can reach the block in the same clock cycle: the explicit start strobe and the lock-loss edge when relaunch is enabled. The bench drives both in one idle cycle. It then checks that a single search runs, with the 28-pulse timing, and that the block stays idle for a long stretch after `done_o`. The bench also provokes each trigger while a search is already running. Here it checks that completion still falls on the original reference-pulse count and that no second search follows.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } cal_state_e;
endpackage

// File: rtl/vbc_rst_sync.sv
module vbc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/vbc_trigger.sv
module vbc_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic auto_i,
  input  logic lock_i,
  output logic req_o
);
  logic lock_q;
  logic lock_d;

  always_comb lock_d = lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  // lock-loss edge counts only when relaunch is enabled
  assign req_o = start_i | (auto_i & lock_q & ~lock_i);
endmodule

// File: rtl/vbc_window.sv
module vbc_window #(
  parameter int WIN_REFS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic ref_tick_i,
  output logic win_end_o
);
  localparam int RC_W = (WIN_REFS > 1) ? $clog2(WIN_REFS) : 1;

  logic [RC_W-1:0] cnt_q;
  logic [RC_W-1:0] cnt_d;
  logic            last;

  assign last      = (cnt_q == RC_W'(WIN_REFS - 1));
  assign win_end_o = run_i & ref_tick_i & last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i && ref_tick_i) begin
      cnt_d = last ? '0 : cnt_q + RC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vbc_fb_meter.sv
module vbc_fb_meter #(
  parameter int WIN_REFS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic win_end_i,
  input  logic fb_tick_i,
  output logic fast_o
);
  localparam int CNT_W = $clog2(2 * WIN_REFS + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum_ext;
  logic [CNT_W-1:0] sum;

  // count including this cycle's pulse, saturating at all ones
  assign sum_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, fb_tick_i};
  assign sum     = sum_ext[CNT_W] ? {CNT_W{1'b1}} : sum_ext[CNT_W-1:0];
  assign fast_o  = ({1'b0, sum} > (CNT_W + 1)'(WIN_REFS));

  always_comb begin
    cnt_d = sum;
    if (clr_i || win_end_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vbc_sar.sv
module vbc_sar #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          fast_i,
  output logic [NB-1:0] code_o
);
  localparam logic [NB-1:0] MID = NB'(1) << (NB - 1);

  logic [NB-1:0] code_q, code_d;
  logic [NB-1:0] mask_q, mask_d;

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    if (load_i) begin
      code_d = MID;
      mask_d = MID;
    end else if (step_i) begin
      code_d = (fast_i ? (code_q & ~mask_q) : code_q) | (mask_q >> 1);
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID;
      mask_q <= MID;
    end else begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/vbc_top.sv
module vbc_top #(
  parameter int NB       = 5,
  parameter int WIN_REFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_start_i,
  input  logic          ref_tick_i,
  input  logic          fb_tick_i,
  input  logic          auto_relaunch_i,
  input  logic          lock_i,
  output logic [NB-1:0] band_o,
  output logic          busy_o,
  output logic          done_o
);
  import vbc_pkg::*;

  localparam int PH_LAST = NB + 1;
  localparam int PH_W    = $clog2(NB + 2);

  logic            rst_n_s;
  logic            req;
  logic            launch;
  logic            win_end;
  logic            fast;
  logic            decide;
  logic            finish;
  cal_state_e      state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            done_q, done_d;

  vbc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  vbc_trigger u_trig (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (cal_start_i),
    .auto_i  (auto_relaunch_i),
    .lock_i  (lock_i),
    .req_o   (req)
  );

  assign launch = (state_q == CAL_IDLE) & req;

  vbc_window #(.WIN_REFS(WIN_REFS)) u_win (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr_i      (launch),
    .run_i      (state_q == CAL_RUN),
    .ref_tick_i (ref_tick_i),
    .win_end_o  (win_end)
  );

  vbc_fb_meter #(.WIN_REFS(WIN_REFS)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr_i     (launch),
    .win_end_i (win_end),
    .fb_tick_i (fb_tick_i),
    .fast_o    (fast)
  );

  // phases: 0 settle, 1..NB decisions (MSB first), NB+1 closing
  assign decide = win_end & (phase_q != '0) & (phase_q <= PH_W'(NB));
  assign finish = win_end & (phase_q == PH_W'(PH_LAST));

  vbc_sar #(.NB(NB)) u_sar (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (launch),
    .step_i (decide),
    .fast_i (fast),
    .code_o (band_o)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    case (state_q)
      CAL_IDLE: begin
        if (launch) begin
          state_d = CAL_RUN;
          phase_d = '0;
        end
      end
      CAL_RUN: begin
        if (finish) begin
          state_d = CAL_IDLE;
          phase_d = '0;
          done_d  = 1'b1;
        end else if (win_end) begin
          phase_d = phase_q + PH_W'(1);
        end
      end
      default: state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= CAL_IDLE;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == CAL_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
  parameter int NB       = 5,
  parameter int WIN_REFS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_tick_i,
  input logic [NB-1:0] band_o,
  input logic          busy_o,
  input logic          done_o
);
  localparam int            TOTAL = (NB + 2) * WIN_REFS;
  localparam int            TW    = $clog2(TOTAL + 1) + 1;
  localparam logic [NB-1:0] MID   = NB'(1) << (NB - 1);

  logic [TW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tick_cnt <= '0;
    else if (!busy_o)    tick_cnt <= '0;
    else if (ref_tick_i) tick_cnt <= tick_cnt + TW'(1);
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tick_cnt == TW'(TOTAL))); // R3
  AST_LAUNCH_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (band_o == MID)); // R2
  AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(ref_tick_i)) |-> $stable(band_o)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(band_o)); // R8
endmodule

bind vbc_top vbc_checker #(.NB(NB), .WIN_REFS(WIN_REFS)) u_vbc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_tick_i (ref_tick_i),
  .band_o     (band_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/vbc_top_test.sv
module vbc_top_test;
  localparam int NB       = 5;
  localparam int WIN_REFS = 4;
  localparam int TOTAL    = (NB + 2) * WIN_REFS;
  localparam int MIDV     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_start = 1'b0;
  logic          ref_tick = 1'b0;
  logic          fb_tick = 1'b0;
  logic          auto_relaunch = 1'b0;
  logic          lock = 1'b1;
  logic [NB-1:0] band_o;
  logic          busy_o;
  logic          done_o;

  int cyc = 0;
  int ref_total = 0;
  int target = 0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vbc_top #(.NB(NB), .WIN_REFS(WIN_REFS)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cal_start_i     (cal_start),
    .ref_tick_i      (ref_tick),
    .fb_tick_i       (fb_tick),
    .auto_relaunch_i (auto_relaunch),
    .lock_i          (lock),
    .band_o          (band_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
  );

  // oscillator model: too fast above the target band (two pulses per
  // reference period), otherwise one pulse per reference period
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      ref_tick = (cyc % 8 == 0);
      if (int'(band_o) > target) fb_tick = (cyc % 8 == 2) || (cyc % 8 == 5);
      else                       fb_tick = (cyc % 8 == 3);
    end
  end

  always @(posedge clk) ref_total <= ref_total + int'(ref_tick);

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
    finish_test();
  end

  // kind: 0 start, 1 lock fall, 2 both. inj: 0 none, 1 start mid-run, 2 lock fall mid-run
  task automatic calib_run(input int tgt, input int kind, input int inj, input bit auto_en);
    int    base, ticks, guard, inj_state;
    bit    seen, c1, c2, stray;
    string ltag, ttag;
    ltag = (kind == 1) ? "R7" : (kind == 2) ? "R10" : "R2";
    ttag = (inj == 1) ? "R6" : (inj == 2) ? "R9" : "R3";
    target = tgt;
    auto_relaunch = auto_en;
    do begin @(posedge clk); #2; end while (cyc % 8 != 4);
    if (kind != 1) cal_start = 1'b1;
    if (kind != 0) lock = 1'b0;
    base = ref_total;
    @(posedge clk); #2;
    cal_start = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b1, ltag, "busy after launch", int'(busy_o), 1);
    check(band_o == NB'(MIDV), ltag, "band at launch", int'(band_o), MIDV);
    seen = 0; c1 = 0; c2 = 0; guard = 0; inj_state = 0;
    while (!seen && guard < 2000) begin
      @(negedge clk);
      guard++;
      ticks = ref_total - base;
      if (inj_state == 1) begin cal_start = 1'b0; inj_state = 2; end
      if (inj != 0 && inj_state == 0 && ticks == 10) begin
        if (inj == 1) cal_start = 1'b1;
        else          lock = 1'b0;
        inj_state = 1;
      end
      if (!c1 && ticks == WIN_REFS) begin
        c1 = 1;
        check(band_o == NB'(MIDV), "R5", "band after settle window", int'(band_o), MIDV);
      end
      if (!c2 && ticks == 2 * WIN_REFS) begin
        c2 = 1;
        check(int'(band_o) == ((tgt & 16) | 8), "R5", "band after first decision",
              int'(band_o), (tgt & 16) | 8);
      end
      if (done_o) begin
        seen = 1;
        check(ticks == TOTAL, ttag, "reference pulses to done", ticks, TOTAL);
        check(busy_o == 1'b0, "R3", "busy with done", int'(busy_o), 0);
        check(int'(band_o) == tgt, "R4", "final band", int'(band_o), tgt);
      end
    end
    cal_start = 1'b0;
    check(seen, ttag, "done seen", int'(seen), 1);
    @(negedge clk);
    check(done_o == 1'b0, "R3", "done width", int'(done_o), 0);
    stray = 0;
    repeat (60) begin
      @(negedge clk);
      if (busy_o || done_o) stray = 1;
    end
    check(!stray, (inj != 0) ? ttag : (kind == 2) ? "R10" : "R3", "no second search",
          int'(stray), 0);
    lock = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int prev;
    bit moved;
    repeat (3) @(negedge clk);
    check(band_o == NB'(MIDV) && !busy_o && !done_o, "R1", "state in reset",
          int'(band_o), MIDV);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(band_o == NB'(MIDV), "R1", "band after reset", int'(band_o), MIDV);
    check(!busy_o && !done_o, "R1", "idle after reset", int'(busy_o) + int'(done_o), 0);

    for (int t = 0; t < 32; t++) calib_run(t, 0, 0, 1'b0);

    calib_run(9, 0, 1, 1'b0);
    calib_run(22, 1, 0, 1'b1);
    calib_run(5, 0, 2, 1'b1);
    calib_run(27, 2, 0, 1'b1);

    // R8: lock loss with relaunch disabled
    auto_relaunch = 1'b0;
    prev = int'(band_o);
    @(posedge clk); #2;
    lock = 1'b0;
    moved = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy_o || int'(band_o) != prev) moved = 1;
    end
    check(!moved, "R8", "lock fall ignored", int'(moved), 0);
    check(int'(band_o) == prev, "R8", "band held", int'(band_o), prev);
    lock = 1'b1;
    repeat (4) @(negedge clk);

    finish_test();
  end
endmodule